// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a memory-mapped 32-bit timer with a plain register bus made of an address, a write enable, write data and combinational read data. A prescale stage divides the input clock by a programmable amount, and each time it rolls over it advances the main up-counter by one. A single compare register is checked against the counter. A small action field chooses what happens when the counter arrives at the compare value: latch an interrupt, return the counter to zero on the following step, or halt counting. Any mix of the three can be chosen.

Software typically uses the block in one of two ways. As a free-running time base, it programs a prescale of zero, leaves all match actions off and reads the counter. As a one-shot event source, it holds the counters in reset through the control register and loads the delay into the prescale register. It sets the compare value to 1 with all three actions enabled, then releases the counters, so that exactly one interrupt is raised after the programmed delay and the timer then halts. The interrupt is a level output that follows a sticky status bit, which software clears by writing a one to it.

Top module: `pmt_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, the timer is disabled, no match action is enabled and `irq_o` is low.
- R2: While counting is allowed, the prescale counter advances every clock. When it reaches the prescale value P, it returns to zero and the main counter steps by one. The main counter therefore steps once every P+1 clocks, and every clock when P is 0.
- R3: The control register is at byte offset 0x004. Bit 0 allows counting. Bit 1 forces both the main counter and the prescale counter to zero for as long as it is set, and it overrides both counting and counter writes. Writing 0 halts the timer and keeps the count.
- R4: With no match action enabled, the main counter runs freely and goes from all ones to zero.
- R5: The match action register is at offset 0x014 and the compare register at offset 0x018. When match action bit 0 is set and the counter steps onto the compare value, status bit 0 is set on that same clock edge. `irq_o` equals that status bit.
- R6: When match action bit 1 is set and the counter already equals the compare value, the next step of the counter loads zero in place of the compare value plus one.
- R7: When match action bit 2 is set, stepping onto the compare value clears control bit 0. Both counters then hold, with the main counter left at the compare value.
- R8: The status register is at offset 0x000. Writing 1 to bit 0 clears it and writing 0 leaves it unchanged. If a clear and a new match fall on the same edge, the bit ends up set.
- R9: The mode register is at offset 0x070 and holds a 2-bit field. Value 0 counts on the internal clock. Any non-zero value keeps both counters from advancing. The field reads back as written.
- R10: The main counter is at offset 0x008 and the prescale register at offset 0x00C. A write takes effect on the next clock edge. Reads return the live value of each register, zero-extended. Any other offset reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Byte offset of the register accessed |
| we | input | 1 | Write strobe, sampled at the rising edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq_o | output | 1 | Level interrupt, high while status bit 0 is set |

## Verification
The bench builds the timer with its default widths: a 32-bit data path and an 8-bit byte address. At these widths the mode register offset 0x070 can be reached. Loading the counter just below all ones brings the 32-bit wrap within a few clocks instead of four billion. A table of prescale values and wait times checks the divide ratio, from divide-by-one up to divide-by-ten. The directed tests then place a status clear on the exact edge of a repeated match, and run a one-shot sequence with stop and reset both enabled.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    // Byte offsets of the software-visible registers
    localparam int unsigned OFS_STAT  = 32'h000;
    localparam int unsigned OFS_CTRL  = 32'h004;
    localparam int unsigned OFS_COUNT = 32'h008;
    localparam int unsigned OFS_PSC   = 32'h00C;
    localparam int unsigned OFS_MACT  = 32'h014;
    localparam int unsigned OFS_MVAL  = 32'h018;
    localparam int unsigned OFS_MODE  = 32'h070;

    localparam int unsigned MODE_W = 2;

    // Control field: bit 1 hold-in-zero, bit 0 run
    typedef struct packed {
        logic hold;
        logic en;
    } ctrl_t;

    // Match action field: bit 2 stop, bit 1 return to zero, bit 0 interrupt
    typedef struct packed {
        logic stop;
        logic zero;
        logic irq;
    } mact_t;

    // One flag per register, used both for address hits and write strobes
    typedef struct packed {
        logic stat;
        logic ctrl;
        logic count;
        logic psc;
        logic mact;
        logic mval;
        logic mode;
    } rsel_t;

endpackage

// File: rtl/pmt_bus_dec.sv
module pmt_bus_dec
    import pmt_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output rsel_t             hit,
    output rsel_t             wr
);

    always_comb begin
        hit       = '0;
        hit.stat  = (addr == ADDR_W'(OFS_STAT));
        hit.ctrl  = (addr == ADDR_W'(OFS_CTRL));
        hit.count = (addr == ADDR_W'(OFS_COUNT));
        hit.psc   = (addr == ADDR_W'(OFS_PSC));
        hit.mact  = (addr == ADDR_W'(OFS_MACT));
        hit.mval  = (addr == ADDR_W'(OFS_MVAL));
        hit.mode  = (addr == ADDR_W'(OFS_MODE));
    end

    always_comb begin
        wr = we ? hit : '0;
    end

endmodule

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic [DATA_W-1:0] limit,
    output logic              tick
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] pc_d, pc_q;

    always_comb begin
        // A limit lowered below the running value still rolls over at once
        tick = run && !clear && (pc_q >= limit);
        pc_d = pc_q;
        if (clear) begin
            pc_d = '0;
        end else if (run) begin
            pc_d = tick ? '0 : pc_q + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              tick,
    input  logic [DATA_W-1:0] cmp_val,
    input  logic              wrap_on_hit,
    output logic [DATA_W-1:0] count,
    output logic              hit_evt
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] cnt_d, cnt_q;
    logic [DATA_W-1:0] stepped;

    always_comb begin
        stepped = (wrap_on_hit && (cnt_q == cmp_val)) ? '0 : cnt_q + ONE;
        cnt_d   = cnt_q;
        hit_evt = 1'b0;
        if (clear) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = load_val;
        end else if (tick) begin
            cnt_d   = stepped;
            hit_evt = (stepped == cmp_val);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/pmt_timer.sv
module pmt_timer
    import pmt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_o
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] psc;
        mact_t             mact;
        logic [DATA_W-1:0] mval;
        logic [MODE_W-1:0] mode;
        logic              stat;
    } regs_t;

    regs_t             r_d, r_q;
    rsel_t             hit, wr;
    logic              run;
    logic              tick;
    logic              match_evt;
    logic              stat_clr;
    logic [DATA_W-1:0] count;

    pmt_bus_dec #(.ADDR_W(ADDR_W)) dec_i (
        .addr (addr),
        .we   (we),
        .hit  (hit),
        .wr   (wr)
    );

    assign run      = r_q.ctrl.en && !r_q.ctrl.hold && (r_q.mode == '0);
    assign stat_clr = wr.stat && wdata[0];

    pmt_prescaler #(.DATA_W(DATA_W)) psc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (r_q.ctrl.hold),
        .run   (run),
        .limit (r_q.psc),
        .tick  (tick)
    );

    pmt_counter #(.DATA_W(DATA_W)) cnt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (r_q.ctrl.hold),
        .load        (wr.count),
        .load_val    (wdata),
        .tick        (tick),
        .cmp_val     (r_q.mval),
        .wrap_on_hit (r_q.mact.zero),
        .count       (count),
        .hit_evt     (match_evt)
    );

    // Next-state computation for the register file
    always_comb begin
        r_d = r_q;
        if (wr.ctrl) begin
            r_d.ctrl = ctrl_t'(wdata[1:0]);
        end else if (match_evt && r_q.mact.stop) begin
            r_d.ctrl.en = 1'b0;
        end
        if (wr.psc)  r_d.psc  = wdata;
        if (wr.mact) r_d.mact = mact_t'(wdata[2:0]);
        if (wr.mval) r_d.mval = wdata;
        if (wr.mode) r_d.mode = wdata[MODE_W-1:0];
        // A new match on the clearing edge keeps the bit set
        r_d.stat = (r_q.stat && !stat_clr) || (match_evt && r_q.mact.irq);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Read path, zero for unmapped offsets
    always_comb begin
        rdata = '0;
        if (hit.stat)  rdata[0]        = r_q.stat;
        if (hit.ctrl)  rdata[1:0]      = r_q.ctrl;
        if (hit.count) rdata           = count;
        if (hit.psc)   rdata           = r_q.psc;
        if (hit.mact)  rdata[2:0]      = r_q.mact;
        if (hit.mval)  rdata           = r_q.mval;
        if (hit.mode)  rdata[MODE_W-1:0] = r_q.mode;
    end

    assign irq_o = r_q.stat;

endmodule

// File: rtl/pmt_timer_chk.sv
module pmt_timer_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] cnt,
    input logic              hold,
    input logic              en,
    input logic [1:0]        mode,
    input logic              irq_o,
    input logic              irq_en,
    input logic              stop_en,
    input logic              stat_clr,
    input logic              cnt_wr,
    input logic              ctrl_wr,
    input logic              match_evt
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && !irq_o && !en)); // R1

    AST_HOLD_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt == '0)); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !cnt_wr) |=> (cnt == $past(cnt) || cnt == $past(cnt) + ONE || cnt == '0)); // R2

    AST_MATCH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && irq_en) |=> irq_o); // R5

    AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && stop_en && !ctrl_wr) |=> !en); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !stat_clr) |=> irq_o); // R8

    AST_MODE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0 && !hold && !cnt_wr) |=> $stable(cnt)); // R9

endmodule

bind pmt_timer pmt_timer_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (count),
    .hold      (r_q.ctrl.hold),
    .en        (r_q.ctrl.en),
    .mode      (r_q.mode),
    .irq_o     (irq_o),
    .irq_en    (r_q.mact.irq),
    .stop_en   (r_q.mact.stop),
    .stat_clr  (stat_clr),
    .cnt_wr    (wr.count),
    .ctrl_wr   (wr.ctrl),
    .match_evt (match_evt)
);

// File: tb/pmt_timer_tb.sv
module pmt_timer_tb_top;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NVEC = 8;

    localparam logic [7:0] A_STAT  = 8'h00;
    localparam logic [7:0] A_CTRL  = 8'h04;
    localparam logic [7:0] A_COUNT = 8'h08;
    localparam logic [7:0] A_PSC   = 8'h0C;
    localparam logic [7:0] A_MACT  = 8'h14;
    localparam logic [7:0] A_MVAL  = 8'h18;
    localparam logic [7:0] A_MODE  = 8'h70;

    // {prescale, clocks waited after enable, expected count}
    localparam logic [95:0] VEC [NVEC] = '{
        {32'd0, 32'd10, 32'd10},
        {32'd1, 32'd10, 32'd5},
        {32'd2, 32'd10, 32'd3},
        {32'd3, 32'd7,  32'd1},
        {32'd4, 32'd20, 32'd4},
        {32'd9, 32'd25, 32'd2},
        {32'd0, 32'd1,  32'd1},
        {32'd7, 32'd8,  32'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o;

    int unsigned n_checks = 0;
    int unsigned n_fail = 0;
    bit          done = 1'b0;

    pmt_timer dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .we    (we),
        .wdata (wdata),
        .rdata (rdata),
        .irq_o (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Called just after a falling edge; one rising edge performs the write
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; we = 1'b1; wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; we = 1'b0;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_chk("R1 stat",  A_STAT,  32'h0);
        rd_chk("R1 ctrl",  A_CTRL,  32'h0);
        rd_chk("R1 count", A_COUNT, 32'h0);
        rd_chk("R1 psc",   A_PSC,   32'h0);
        rd_chk("R1 mact",  A_MACT,  32'h0);
        rd_chk("R1 mval",  A_MVAL,  32'h0);
        rd_chk("R1 mode",  A_MODE,  32'h0);
        chk("R1 irq", {31'h0, irq_o}, 32'h0);

        // R2: divide ratios from the vector table
        for (int i = 0; i < NVEC; i++) begin
            wr(A_CTRL, 32'h2);
            wr(A_PSC, VEC[i][95:64]);
            wr(A_CTRL, 32'h1);
            idle(int'(VEC[i][63:32]));
            rd_chk("R2 prescale divide", A_COUNT, VEC[i][31:0]);
        end

        // R3: writing 0 halts and keeps the count
        wr(A_CTRL, 32'h2);
        wr(A_PSC, 32'h0);
        wr(A_CTRL, 32'h1);
        idle(3);
        wr(A_CTRL, 32'h0);
        idle(5);
        rd_chk("R3 halt keeps count", A_COUNT, 32'd4);

        // R4 / R10: wrap from all ones, counter write lands next edge
        wr(A_CTRL, 32'h2);
        wr(A_CTRL, 32'h0);
        wr(A_COUNT, 32'hFFFF_FFFE);
        rd_chk("R10 count write", A_COUNT, 32'hFFFF_FFFE);
        wr(A_CTRL, 32'h1);
        idle(1);
        rd_chk("R4 all ones", A_COUNT, 32'hFFFF_FFFF);
        idle(2);
        rd_chk("R4 wrapped", A_COUNT, 32'h1);

        // R5 / R6 / R8: interrupt plus return to zero, period 5
        wr(A_CTRL, 32'h2);
        wr(A_MVAL, 32'd4);
        wr(A_MACT, 32'h3);
        wr(A_CTRL, 32'h1);
        idle(3);
        chk("R5 no irq before match", {31'h0, irq_o}, 32'h0);
        idle(1);
        chk("R5 irq on match", {31'h0, irq_o}, 32'h1);
        rd_chk("R5 status bit", A_STAT, 32'h1);
        rd_chk("R5 count at match", A_COUNT, 32'd4);
        idle(1);
        rd_chk("R6 return to zero", A_COUNT, 32'd0);
        wr(A_STAT, 32'h0);
        chk("R8 write 0 keeps irq", {31'h0, irq_o}, 32'h1);
        wr(A_STAT, 32'h1);
        chk("R8 write 1 clears irq", {31'h0, irq_o}, 32'h0);
        rd_chk("R6 count after clear", A_COUNT, 32'd2);
        idle(2);
        chk("R5 irq on second match", {31'h0, irq_o}, 32'h1);

        // R8: clear on the same edge as a match, period 3
        wr(A_CTRL, 32'h2);
        wr(A_STAT, 32'h1);
        wr(A_MVAL, 32'd2);
        wr(A_CTRL, 32'h1);
        idle(2);
        chk("R8 first match", {31'h0, irq_o}, 32'h1);
        idle(2);
        wr(A_STAT, 32'h1);
        chk("R8 set wins over clear", {31'h0, irq_o}, 32'h1);
        rd_chk("R8 count at match", A_COUNT, 32'd2);
        wr(A_STAT, 32'h1);
        chk("R8 clear later", {31'h0, irq_o}, 32'h0);

        // R7: stop only, no interrupt
        wr(A_CTRL, 32'h2);
        wr(A_STAT, 32'h1);
        wr(A_MVAL, 32'd3);
        wr(A_MACT, 32'h4);
        wr(A_PSC, 32'd1);
        wr(A_CTRL, 32'h1);
        idle(20);
        rd_chk("R7 frozen at match", A_COUNT, 32'd3);
        rd_chk("R7 enable cleared", A_CTRL, 32'h0);
        chk("R7 no irq without bit 0", {31'h0, irq_o}, 32'h0);

        // R7 / R6 / R5: one-shot with all actions
        wr(A_CTRL, 32'h2);
        wr(A_MVAL, 32'd1);
        wr(A_MACT, 32'h7);
        wr(A_PSC, 32'd4);
        wr(A_CTRL, 32'h1);
        idle(4);
        rd_chk("R2 one-shot before delay", A_COUNT, 32'd0);
        chk("R5 one-shot no irq yet", {31'h0, irq_o}, 32'h0);
        idle(1);
        rd_chk("R7 one-shot count", A_COUNT, 32'd1);
        chk("R5 one-shot irq", {31'h0, irq_o}, 32'h1);
        rd_chk("R7 one-shot halted", A_CTRL, 32'h0);
        idle(5);
        rd_chk("R7 one-shot stays", A_COUNT, 32'd1);

        // R3: hold forces zero and overrides counter writes
        wr(A_CTRL, 32'h2);
        wr(A_STAT, 32'h1);
        wr(A_MACT, 32'h0);
        wr(A_PSC, 32'h0);
        wr(A_CTRL, 32'h1);
        idle(4);
        rd_chk("R3 running", A_COUNT, 32'd4);
        wr(A_CTRL, 32'h3);
        idle(3);
        rd_chk("R3 hold zeroes", A_COUNT, 32'd0);
        wr(A_COUNT, 32'd9);
        rd_chk("R3 hold beats write", A_COUNT, 32'd0);
        wr(A_CTRL, 32'h1);
        idle(6);
        rd_chk("R3 restart from zero", A_COUNT, 32'd6);

        // R9: non-zero mode keeps the counter still
        wr(A_CTRL, 32'h2);
        wr(A_MODE, 32'h1);
        wr(A_CTRL, 32'h1);
        idle(5);
        rd_chk("R9 mode idle", A_COUNT, 32'd0);
        rd_chk("R9 mode readback", A_MODE, 32'h1);
        wr(A_MODE, 32'h0);
        idle(3);
        rd_chk("R9 mode 0 counts", A_COUNT, 32'd3);

        // R10: readback and unmapped offsets
        wr(A_CTRL, 32'h0);
        wr(A_PSC, 32'h1234_5678);
        rd_chk("R10 psc readback", A_PSC, 32'h1234_5678);
        wr(A_MVAL, 32'hCAFE_0001);
        rd_chk("R10 mval readback", A_MVAL, 32'hCAFE_0001);
        wr(8'h10, 32'hFFFF_FFFF);
        rd_chk("R10 unmapped 0x10", 8'h10, 32'h0);
        rd_chk("R10 unmapped 0x7C", 8'h7C, 32'h0);
        rd_chk("R10 mact unchanged", A_MACT, 32'h0);

        summary();
    end

endmodule